// File: doc/BRIEF.md
# Serial Controller Host Register Bank

This block is the processor-facing register file of a classic asynchronous serial controller. A host reaches it through an 8-byte window with an 8-bit data bus. The block decodes each access and keeps the configuration state that the rest of the controller uses: the baud divisor, the character framing, the FIFO setup, the interrupt enables and the modem control lines. It also turns data-port accesses and FIFO-reset commands into single-cycle strobes for the shifters and FIFOs.

Several offsets act differently on a read and on a write. A bank-select bit in the line control register (bit 7) switches offsets 0 and 1 from the data port and interrupt enables over to the two divisor bytes. Status values come from outside the block and are only forwarded to the host: received byte, line status, modem status and interrupt identity.

Every output is registered. A write takes effect on the clock edge that samples it. Read data and strobes appear in the cycle after the access.

Top module: `uart_regbank`

## Requirements
- R1: After reset, LCR reads 0x03, which gives word_len=3, one stop bit and no parity. IER, MCR, SCR and the divisor read 0, baud_run is 0, and all strobes are low.
- R2: With LCR bit 7 at 0, a write to offset 0 raises tx_push for exactly one cycle after the access, with tx_byte equal to the written byte. The divisor is unchanged.
- R3: With LCR bit 7 at 0, a read of offset 0 returns rx_byte and raises rx_pop for exactly one cycle. With bit 7 at 1, a read of offset 0 raises no rx_pop.
- R4: With LCR bit 7 at 1, offset 0 reads and writes divisor[7:0] and offset 1 reads and writes divisor[15:8]. These writes raise no tx_push and leave the interrupt enable register unchanged.
- R5: Offset 1 with LCR bit 7 at 0 holds the interrupt enables. Only wdata[3:0] is kept; it drives irq_en and reads back with bits 7:4 at 0.
- R6: Offset 4 keeps only wdata[4:0]. Bit 0 drives dtr, bit 1 rts, bit 2 aux1, bit 3 aux2 and bit 4 loopback. Bits 7:5 read back as 0.
- R7: A write to offset 2 sets fifo_en from bit 0 and rx_trig from bits 7:6. Bit 1 gives a one-cycle rx_fifo_clr pulse and bit 2 a one-cycle tx_fifo_clr pulse. Neither bit is stored. A read of offset 2 returns int_ident.
- R8: Offset 3 reads back all 8 bits as written. Bits 1:0 drive word_len, bit 2 two_stop, bit 3 par_en, bit 4 par_even, bit 5 par_stick and bit 6 brk.
- R9: Offset 5 reads line_stat and offset 6 reads modem_stat. Offset 7 is an 8-bit scratch register with no side effects.
- R10: baud_run is 1 exactly when the divisor is nonzero, so a divisor of 0 keeps the baud generator idle.
- R11: bus_rdata changes only after a read access and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_byte | input | 8 | Head of the receive path |
| line_stat | input | 8 | Line status from the serial core |
| modem_stat | input | 8 | Modem status from the serial core |
| int_ident | input | 8 | Interrupt identity from the interrupt logic |
| tx_push | output | 1 | One-cycle transmit push strobe |
| tx_byte | output | 8 | Byte that goes with tx_push |
| rx_pop | output | 1 | One-cycle receive pop strobe |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO reset |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO reset |
| fifo_en | output | 1 | FIFO mode enable |
| rx_trig | output | 2 | Receive trigger level select |
| divisor | output | 16 | Baud divisor |
| baud_run | output | 1 | Divisor is nonzero |
| word_len | output | 2 | Character length code (0 = 5 bits, 3 = 8 bits) |
| two_stop | output | 1 | Two stop bits |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity |
| par_stick | output | 1 | Stick parity |
| brk | output | 1 | Force break |
| irq_en | output | 4 | Interrupt enables |
| dtr | output | 1 | Modem control bit 0 |
| rts | output | 1 | Modem control bit 1 |
| aux1 | output | 1 | Modem control bit 2 |
| aux2 | output | 1 | Modem control bit 3 |
| loopback | output | 1 | Loopback mode select |

## Verification
The hardest situation to reach is the banked one. The divisor bytes share offsets 0 and 1 with the data port and the interrupt enables, so a leak in either direction is invisible unless both sides are checked. The stimulus first puts a known value in the interrupt enables. It then sets the bank bit, writes and reads both divisor bytes while watching that no push or pop strobe fires, clears the bank bit again and reads the interrupt enables back unchanged. The FIFO-reset bits never show up in any readback, so they are checked only through their strobe ports in the single cycle after the write.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int OFS_DATA = 0;
  localparam int OFS_IER  = 1;
  localparam int OFS_FIFO = 2;
  localparam int OFS_LCR  = 3;
  localparam int OFS_MCR  = 4;
  localparam int OFS_LSR  = 5;
  localparam int OFS_MSR  = 6;
  localparam int OFS_SCR  = 7;

  localparam logic [7:0] LCR_RST = 8'h03;

  typedef struct packed {
    logic       bank;
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wlen;
  } frame_cfg_t;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode #(
  parameter int ADDR_W    = 3,
  parameter int DIV_BYTES = 2
) (
  input  logic                   sel,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   bank,
  output logic [(1<<ADDR_W)-1:0] reg_wr,
  output logic [DIV_BYTES-1:0]   div_wr,
  output logic                   pop_req
);
  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:0] hit;
  assign hit = sel ? (NREG'(1) << addr) : '0;

  for (genvar i = 0; i < NREG; i++) begin : g_ofs
    if (i < DIV_BYTES) begin : g_banked
      assign reg_wr[i] = we & hit[i] & ~bank;
      assign div_wr[i] = we & hit[i] & bank;
    end else begin : g_plain
      assign reg_wr[i] = we & hit[i];
    end
  end

  assign pop_req = ~we & hit[uart_rb_pkg::OFS_DATA] & ~bank;
endmodule

// File: rtl/uart_rb_ctrl.sv
module uart_rb_ctrl #(
  parameter int DATA_W    = 8,
  parameter int NREG      = 8,
  parameter int DIV_BYTES = 2,
  parameter int IER_BITS  = 4,
  parameter int MCR_BITS  = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NREG-1:0]             reg_wr,
  input  logic [DIV_BYTES-1:0]        div_wr,
  input  logic                        pop_req,
  output logic [DATA_W-1:0]           lcr_q,
  output logic [IER_BITS-1:0]         ier_q,
  output logic [MCR_BITS-1:0]         mcr_q,
  output logic [DATA_W-1:0]           scr_q,
  output logic [DIV_BYTES*DATA_W-1:0] div_q,
  output logic                        baud_run_q,
  output logic                        fifo_en_q,
  output logic [1:0]                  trig_q,
  output logic                        tx_push_q,
  output logic [DATA_W-1:0]           tx_data_q,
  output logic                        rx_pop_q,
  output logic                        rx_clr_q,
  output logic                        tx_clr_q
);
  import uart_rb_pkg::*;
  localparam int DIV_W = DIV_BYTES * DATA_W;

  logic [DIV_W-1:0] div_nxt;

  always_comb begin
    div_nxt = div_q;
    for (int b = 0; b < DIV_BYTES; b++) begin
      if (div_wr[b]) div_nxt[b*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q      <= '0;
      baud_run_q <= 1'b0;
    end else begin
      div_q      <= div_nxt;
      baud_run_q <= |div_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q <= DATA_W'(LCR_RST);
      ier_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
    end else begin
      if (reg_wr[OFS_LCR]) lcr_q <= wdata;
      if (reg_wr[OFS_IER]) ier_q <= wdata[IER_BITS-1:0];
      if (reg_wr[OFS_MCR]) mcr_q <= wdata[MCR_BITS-1:0];
      if (reg_wr[OFS_SCR]) scr_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en_q <= 1'b0;
      trig_q    <= 2'b00;
      rx_clr_q  <= 1'b0;
      tx_clr_q  <= 1'b0;
    end else begin
      if (reg_wr[OFS_FIFO]) begin
        fifo_en_q <= wdata[0];
        trig_q    <= wdata[DATA_W-1 -: 2];
      end
      rx_clr_q <= reg_wr[OFS_FIFO] & wdata[1];
      tx_clr_q <= reg_wr[OFS_FIFO] & wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_push_q <= 1'b0;
      tx_data_q <= '0;
      rx_pop_q  <= 1'b0;
    end else begin
      tx_push_q <= reg_wr[OFS_DATA];
      rx_pop_q  <= pop_req;
      if (reg_wr[OFS_DATA]) tx_data_q <= wdata;
    end
  end

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(tx_push_q && rx_pop_q)); // R3
endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int DIV_BYTES = 2,
  parameter int IER_BITS  = 4,
  parameter int MCR_BITS  = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        bank,
  input  logic [DATA_W-1:0]           rx_byte,
  input  logic [DATA_W-1:0]           iid,
  input  logic [DATA_W-1:0]           lsr,
  input  logic [DATA_W-1:0]           msr,
  input  logic [DATA_W-1:0]           lcr,
  input  logic [IER_BITS-1:0]         ier,
  input  logic [MCR_BITS-1:0]         mcr,
  input  logic [DATA_W-1:0]           scr,
  input  logic [DIV_BYTES*DATA_W-1:0] div,
  output logic [DATA_W-1:0]           rdata_q
);
  import uart_rb_pkg::*;

  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if (bank && int'(addr) < DIV_BYTES) begin
      rd_nxt = div[int'(addr)*DATA_W +: DATA_W];
    end else begin
      case (int'(addr))
        OFS_DATA: rd_nxt = rx_byte;
        OFS_IER:  rd_nxt = {{(DATA_W-IER_BITS){1'b0}}, ier};
        OFS_FIFO: rd_nxt = iid;
        OFS_LCR:  rd_nxt = lcr;
        OFS_MCR:  rd_nxt = {{(DATA_W-MCR_BITS){1'b0}}, mcr};
        OFS_LSR:  rd_nxt = lsr;
        OFS_MSR:  rd_nxt = msr;
        OFS_SCR:  rd_nxt = scr;
        default:  rd_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nxt;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata_q)); // R11
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int DIV_BYTES = 2,
  parameter int IER_BITS  = 4,
  parameter int MCR_BITS  = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [DATA_W-1:0]           rx_byte,
  input  logic [DATA_W-1:0]           line_stat,
  input  logic [DATA_W-1:0]           modem_stat,
  input  logic [DATA_W-1:0]           int_ident,
  output logic                        tx_push,
  output logic [DATA_W-1:0]           tx_byte,
  output logic                        rx_pop,
  output logic                        rx_fifo_clr,
  output logic                        tx_fifo_clr,
  output logic                        fifo_en,
  output logic [1:0]                  rx_trig,
  output logic [DIV_BYTES*DATA_W-1:0] divisor,
  output logic                        baud_run,
  output logic [1:0]                  word_len,
  output logic                        two_stop,
  output logic                        par_en,
  output logic                        par_even,
  output logic                        par_stick,
  output logic                        brk,
  output logic [IER_BITS-1:0]         irq_en,
  output logic                        dtr,
  output logic                        rts,
  output logic                        aux1,
  output logic                        aux2,
  output logic                        loopback
);
  import uart_rb_pkg::*;
  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:0]      reg_wr;
  logic [DIV_BYTES-1:0] div_wr;
  logic                 pop_req;
  logic [DATA_W-1:0]    lcr_q;
  logic [MCR_BITS-1:0]  mcr_q;
  logic [DATA_W-1:0]    scr_q;
  frame_cfg_t           cfg;

  assign cfg = frame_cfg_t'(lcr_q[7:0]);

  uart_rb_decode #(.ADDR_W(ADDR_W), .DIV_BYTES(DIV_BYTES)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .bank(cfg.bank),
    .reg_wr(reg_wr), .div_wr(div_wr), .pop_req(pop_req)
  );

  uart_rb_ctrl #(.DATA_W(DATA_W), .NREG(NREG), .DIV_BYTES(DIV_BYTES),
                 .IER_BITS(IER_BITS), .MCR_BITS(MCR_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .wdata(bus_wdata), .reg_wr(reg_wr), .div_wr(div_wr),
    .pop_req(pop_req), .lcr_q(lcr_q), .ier_q(irq_en), .mcr_q(mcr_q),
    .scr_q(scr_q), .div_q(divisor), .baud_run_q(baud_run), .fifo_en_q(fifo_en),
    .trig_q(rx_trig), .tx_push_q(tx_push), .tx_data_q(tx_byte),
    .rx_pop_q(rx_pop), .rx_clr_q(rx_fifo_clr), .tx_clr_q(tx_fifo_clr)
  );

  uart_rb_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_BYTES(DIV_BYTES),
                  .IER_BITS(IER_BITS), .MCR_BITS(MCR_BITS)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_sel & ~bus_we), .addr(bus_addr),
    .bank(cfg.bank), .rx_byte(rx_byte), .iid(int_ident), .lsr(line_stat),
    .msr(modem_stat), .lcr(lcr_q), .ier(irq_en), .mcr(mcr_q), .scr(scr_q),
    .div(divisor), .rdata_q(bus_rdata)
  );

  assign word_len  = cfg.wlen;
  assign two_stop  = cfg.two_stop;
  assign par_en    = cfg.par_en;
  assign par_even  = cfg.even;
  assign par_stick = cfg.stick;
  assign brk       = cfg.brk;
  assign dtr       = mcr_q[0];
  assign rts       = mcr_q[1];
  assign aux1      = mcr_q[2];
  assign aux2      = mcr_q[3];
  assign loopback  = mcr_q[4];

  AST_LCR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (word_len == 2'd3 && !par_en && !two_stop && !cfg.bank)); // R1
  AST_PUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(bus_sel && bus_we && bus_addr == '0 && !cfg.bank)); // R2
  AST_POP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(bus_sel && !bus_we && bus_addr == '0 && !cfg.bank)); // R3
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_sel && bus_we && cfg.bank && int'(bus_addr) < DIV_BYTES)
      |-> $stable(divisor)); // R4
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rx_fifo_clr || tx_fifo_clr) |-> $past(bus_sel && bus_we && int'(bus_addr) == OFS_FIFO)); // R7
  AST_BAUD_IDLE: assert property (@(posedge clk) disable iff (rst)
    baud_run == (divisor != '0)); // R10
endmodule

// File: tb/uart_regbank_test.sv
module uart_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  rx_byte = 8'h00, line_stat = 8'h60, modem_stat = 8'hB0, int_ident = 8'hC1;
  logic        tx_push, rx_pop, rx_fifo_clr, tx_fifo_clr, fifo_en, baud_run;
  logic [7:0]  tx_byte;
  logic [1:0]  rx_trig, word_len;
  logic [15:0] divisor;
  logic        two_stop, par_en, par_even, par_stick, brk;
  logic [3:0]  irq_en;
  logic        dtr, rts, aux1, aux2, loopback;

  int checks = 0, failures = 0;
  logic done = 1'b0;
  logic [7:0] rd_v;
  logic push_v, pop_v, rclr_v, tclr_v;

  always #2.5 clk = ~clk;

  uart_regbank uut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    push_v = tx_push; rclr_v = rx_fifo_clr; tclr_v = tx_fifo_clr;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    rd_v = bus_rdata; pop_v = rx_pop;
  endtask

  task automatic t_reset;
    check("R1 divisor", divisor, 16'h0);
    check("R1 baud_run", {15'b0, baud_run}, 16'h0);
    check("R1 strobes", {12'b0, tx_push, rx_pop, rx_fifo_clr, tx_fifo_clr}, 16'h0);
    rd(3); check("R1 LCR", {8'h0, rd_v}, 16'h0003);
    check("R1 framing", {12'b0, word_len, two_stop, par_en}, 16'h000C);
    rd(1); check("R1 IER", {8'h0, rd_v}, 16'h0);
    rd(4); check("R1 MCR", {8'h0, rd_v}, 16'h0);
    rd(7); check("R1 SCR", {8'h0, rd_v}, 16'h0);
  endtask

  task automatic t_tx_push;
    wr(0, 8'hA5);
    check("R2 push", {15'b0, push_v}, 16'h1);
    check("R2 tx_byte", {8'h0, tx_byte}, 16'h00A5);
    @(negedge clk);
    check("R2 push one cycle", {15'b0, tx_push}, 16'h0);
    check("R2 divisor kept", divisor, 16'h0);
  endtask

  task automatic t_rx_pop;
    rx_byte = 8'h3C;
    rd(0);
    check("R3 rx data", {8'h0, rd_v}, 16'h003C);
    check("R3 pop", {15'b0, pop_v}, 16'h1);
    @(negedge clk);
    check("R3 pop one cycle", {15'b0, rx_pop}, 16'h0);
  endtask

  task automatic t_divisor;
    wr(1, 8'h05);
    wr(3, 8'h83);
    wr(0, 8'h34);
    check("R4 no push on div low", {15'b0, push_v}, 16'h0);
    wr(1, 8'h12);
    check("R4 divisor", divisor, 16'h1234);
    check("R10 baud_run on", {15'b0, baud_run}, 16'h1);
    rd(0);
    check("R4 read div low", {8'h0, rd_v}, 16'h0034);
    check("R3 no pop when banked", {15'b0, pop_v}, 16'h0);
    rd(1); check("R4 read div high", {8'h0, rd_v}, 16'h0012);
    wr(0, 8'h00); wr(1, 8'h00);
    check("R10 baud_run idle", {15'b0, baud_run}, 16'h0);
    wr(1, 8'h01);
    check("R10 high byte only", {15'b0, baud_run}, 16'h1);
    wr(3, 8'h03);
    rd(1); check("R4 IER untouched", {8'h0, rd_v}, 16'h0005);
    check("R4 irq_en untouched", {12'b0, irq_en}, 16'h0005);
    check("R4 divisor after unbank", divisor, 16'h0100);
  endtask

  task automatic t_ier;
    wr(1, 8'hFF);
    rd(1); check("R5 IER mask", {8'h0, rd_v}, 16'h000F);
    check("R5 irq_en", {12'b0, irq_en}, 16'h000F);
    wr(1, 8'h3A);
    check("R5 irq_en low nibble", {12'b0, irq_en}, 16'h000A);
  endtask

  task automatic t_mcr;
    wr(4, 8'hFF);
    rd(4); check("R6 MCR mask", {8'h0, rd_v}, 16'h001F);
    wr(4, 8'h12);
    check("R6 pins 0x12", {11'b0, loopback, aux2, aux1, rts, dtr}, 16'h0012);
    wr(4, 8'h0D);
    check("R6 pins 0x0D", {11'b0, loopback, aux2, aux1, rts, dtr}, 16'h000D);
  endtask

  task automatic t_fcr;
    wr(2, 8'hC7);
    check("R7 rx clr", {15'b0, rclr_v}, 16'h1);
    check("R7 tx clr", {15'b0, tclr_v}, 16'h1);
    check("R7 fifo_en trig", {13'b0, fifo_en, rx_trig}, 16'h0007);
    @(negedge clk);
    check("R7 clr self-clear", {14'b0, rx_fifo_clr, tx_fifo_clr}, 16'h0);
    rd(2); check("R7 read iid", {8'h0, rd_v}, 16'h00C1);
    check("R7 read no clr", {14'b0, rx_fifo_clr, tx_fifo_clr}, 16'h0);
    wr(2, 8'h42);
    check("R7 rx clr only", {14'b0, rclr_v, tclr_v}, 16'h0002);
    check("R7 fifo_en off trig 1", {13'b0, fifo_en, rx_trig}, 16'h0001);
  endtask

  task automatic t_lcr;
    wr(3, 8'h3D);
    rd(3); check("R8 LCR readback", {8'h0, rd_v}, 16'h003D);
    check("R8 fields 3D", {9'b0, brk, par_stick, par_even, par_en, two_stop, word_len}, 16'h003D);
    wr(3, 8'h42);
    check("R8 fields 42", {9'b0, brk, par_stick, par_even, par_en, two_stop, word_len}, 16'h0042);
    wr(3, 8'h03);
  endtask

  task automatic t_status;
    rd(5); check("R9 line stat", {8'h0, rd_v}, 16'h0060);
    rd(6); check("R9 modem stat", {8'h0, rd_v}, 16'h00B0);
    wr(7, 8'h9E);
    check("R9 scratch no push", {15'b0, push_v}, 16'h0);
    rd(7); check("R9 scratch", {8'h0, rd_v}, 16'h009E);
  endtask

  task automatic t_hold;
    rd(7);
    wr(7, 8'h11);
    check("R11 held over write", {8'h0, bus_rdata}, 16'h009E);
    repeat (3) @(negedge clk);
    check("R11 held idle", {8'h0, bus_rdata}, 16'h009E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_tx_push();
    t_rx_pop();
    t_divisor();
    t_ier();
    t_mcr();
    t_fcr();
    t_lcr();
    t_status();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule